// File: doc/BRIEF.md
# Converter Serial Port with Shared Data-Ready Output

This block is the digital serial slave of a sigma-delta converter. A host frames transfers with an active-low chip select, clocks bits with SCLK and sends data on DIN. Each transfer opens with an 8-bit command byte. That byte picks one internal register, sets the direction, and can switch the port into a continuous result stream. All shifts are MSB first. A stand-in for the modulator and filter delivers each finished result as a one-cycle strobe with the result word. The port stores that word and tells the host a result is ready by pulling the shared output pin low.

The single output pin has two jobs. While a read is shifting out, it carries the read bits. At all other times it shows the inverted ready flag. The pin drives only while chip select is low. Chip select may stay low for good, which gives a three-wire link. The serial inputs pass through a two-flop synchroniser into the system clock domain. SCLK edges are found there. Output bits change on SCLK falling edges, and DIN is sampled on rising edges.

Top module: `cvt_serial_port`

## Requirements
- R1: `dout_oe` is 1 exactly when the synchronised chip select is low; it follows `cs_n` two system clocks later and is 0 during and right after reset.
- R2: The command byte is 8 bits, MSB first. Bit 7 must be 0 for the byte to act. A byte with bit 7 set is dropped, and the port keeps waiting for a command byte.
- R3: Command bit 6 picks the direction (1 read, 0 write) and bits 5:3 pick the register: 0 status (8 bits), 1 mode (16 bits), 2 setup (16 bits), 3 result (DATA_W bits). A write replaces mode or setup. A read returns the stored value. After reset, mode is 0x000A and setup is 0x0710. `rate_code` is mode bits 3:0.
- R4: `notch` decodes `rate_code`: 4'b1000 gives 1 (60 Hz), 4'b1001 gives 2 (50 Hz), 4'b1010 gives 3 (both), and any other code gives 0.
- R5: A `conv_done` strobe stores `conv_word`. Outside a read shift, the output pin then goes low.
- R6: Reading the result register (command 0x58) returns the stored word unchanged, MSB first. When its last bit is taken, the pin returns high.
- R7: An `upd_near` strobe drives the pin high even if the result was never read.
- R8: Outside continuous-read mode, the result can be read again while ready is high, and it returns the same word.
- R9: Command 0x5C (result read with bit 2 set) enters continuous-read mode. Every later DATA_W-bit word is a result with no command byte, and the mode lasts across chip-select frames. A word clocked out before a new conversion arrives reads as all ones.
- R10: In continuous-read mode, if the first 8 DIN bits of a word equal 0x58, the mode ends after that word and the port waits for a command byte.
- R11: If chip select rises partway through a frame, the partial bits are discarded. The next frame starts with a command byte, or with a result word while continuous read is on.
- R12: The status register reads bit 7 as the inverted ready flag and bit 6 as continuous-read mode, with all other bits 0.
- R13: During a read, the output bit changes only after a detected SCLK falling edge. It holds steady while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Read data or inverted ready flag |
| dout_oe | output | 1 | Drive enable for `dout` |
| conv_done | input | 1 | One-cycle strobe: a result is finished |
| conv_word | input | DATA_W | Offset-binary result that goes with `conv_done` |
| upd_near | input | 1 | One-cycle strobe: the next update is close |
| rate_code | output | 4 | Output word rate field from the mode register |
| notch | output | 2 | Decoded mains rejection selection |

## Verification
The assertions assume SCLK and chip select change slowly next to the system clock. Each SCLK level and each chip-select change must last several clocks, so every edge is seen once after the synchroniser. The bench holds each SCLK phase for six clocks. It changes chip select only while SCLK is high, and it settles for four clocks after each frame change. The strobes `conv_done` and `upd_near` are assumed to be single-cycle pulses. The bench drives them for exactly one clock and only between transfers, so a result never lands while a read shift is running.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_MODE   = 3'd1,
        SEL_SETUP  = 3'd2,
        SEL_RESULT = 3'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        NOTCH_NONE = 2'd0,
        NOTCH_60   = 2'd1,
        NOTCH_50   = 2'd2,
        NOTCH_BOTH = 2'd3
    } notch_e;

    // command byte, MSB first on the wire
    typedef struct packed {
        logic     wen_n;
        logic     rd;
        reg_sel_e sel;
        logic     stream;
        logic [1:0] spare;
    } cmd_t;

    localparam int          CMD_W      = 8;
    localparam int          STAT_W     = 8;
    localparam int          CTRL_W     = 16;
    localparam logic [15:0] MODE_RST   = 16'h000A;
    localparam logic [15:0] SETUP_RST  = 16'h0710;
    localparam logic [7:0]  STREAM_END = 8'h58;

    function automatic notch_e notch_of(input logic [3:0] fs);
        case (fs)
            4'b1000: return NOTCH_60;
            4'b1001: return NOTCH_50;
            4'b1010: return NOTCH_BOTH;
            default: return NOTCH_NONE;
        endcase
    endfunction

    function automatic int unsigned sel_len(input reg_sel_e s, input int unsigned dw);
        case (s)
            SEL_MODE, SEL_SETUP: return CTRL_W;
            SEL_RESULT:          return dw;
            default:             return STAT_W;
        endcase
    endfunction

endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic frame_on,
    output logic frame_end,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] cs_p, ck_p, d_p;
    logic              ck_last, cs_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p    <= '1;
            ck_p    <= '1;
            d_p     <= '0;
            ck_last <= 1'b1;
            cs_last <= 1'b1;
        end else begin
            cs_p    <= {cs_p[STAGES-2:0], cs_n};
            ck_p    <= {ck_p[STAGES-2:0], sclk};
            d_p     <= {d_p[STAGES-2:0], din};
            ck_last <= ck_p[TOP];
            cs_last <= cs_p[TOP];
        end
    end

    assign frame_on  = !cs_p[TOP];
    assign frame_end = cs_p[TOP] && !cs_last;
    assign sclk_rise = frame_on && ck_p[TOP] && !ck_last;
    assign sclk_fall = frame_on && !ck_p[TOP] && ck_last;
    assign din_s     = d_p[TOP];

endmodule

// File: rtl/cvt_frame.sv
module cvt_frame
    import cvt_pkg::*;
#(
    parameter int DATA_W = 24,
    localparam int MAXW  = (DATA_W > CTRL_W) ? DATA_W : CTRL_W,
    localparam int CW    = $clog2(MAXW + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_on,
    input  logic              frame_end,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_s,
    input  logic [MAXW-1:0]   rd_word,
    input  logic              rdy_n,
    output reg_sel_e          sel,
    output logic              wr_stb,
    output logic [CTRL_W-1:0] wr_data,
    output logic              rd_done,
    output logic              stream_on,
    output logic              dout
);
    phase_e              ph;
    logic [CW-1:0]       cnt, len;
    logic [CTRL_W-2:0]   rx;
    logic [MAXW-1:0]     tx;
    logic                started, quit;
    cmd_t                cmd_now;
    logic                last_bit, end_now;

    assign cmd_now  = cmd_t'({rx[CMD_W-2:0], din_s});
    assign last_bit = (cnt == len - CW'(1));
    assign end_now  = stream_on && (cnt == CW'(CMD_W - 1)) &&
                      ({rx[CMD_W-2:0], din_s} == STREAM_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_CMD;
            cnt       <= '0;
            len       <= CW'(CMD_W);
            sel       <= SEL_STATUS;
            rx        <= '0;
            tx        <= '0;
            started   <= 1'b0;
            quit      <= 1'b0;
            stream_on <= 1'b0;
            wr_stb    <= 1'b0;
            wr_data   <= '0;
            rd_done   <= 1'b0;
        end else begin
            wr_stb  <= 1'b0;
            rd_done <= 1'b0;
            if (!frame_on) begin
                // frame closed or aborted: drop partial word
                cnt     <= '0;
                started <= 1'b0;
                quit    <= 1'b0;
                if (stream_on) begin
                    ph  <= PH_RD;
                    sel <= SEL_RESULT;
                    len <= CW'(DATA_W);
                end else begin
                    ph  <= PH_CMD;
                end
            end else if (sclk_rise) begin
                rx <= {rx[CTRL_W-3:0], din_s};
                case (ph)
                    PH_CMD: begin
                        if (cnt == CW'(CMD_W - 1)) begin
                            cnt <= '0;
                            if (!cmd_now.wen_n) begin
                                sel <= cmd_now.sel;
                                len <= CW'(sel_len(cmd_now.sel, DATA_W));
                                if (cmd_now.rd) begin
                                    ph      <= PH_RD;
                                    started <= 1'b0;
                                    if (cmd_now.sel == SEL_RESULT && cmd_now.stream)
                                        stream_on <= 1'b1;
                                end else begin
                                    ph <= PH_WR;
                                end
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    PH_WR: begin
                        if (last_bit) begin
                            wr_stb  <= 1'b1;
                            wr_data <= {rx, din_s};
                            ph      <= PH_CMD;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    PH_RD: begin
                        if (end_now) quit <= 1'b1;
                        if (last_bit) begin
                            rd_done <= 1'b1;
                            started <= 1'b0;
                            cnt     <= '0;
                            quit    <= 1'b0;
                            if (stream_on && !(quit || end_now)) begin
                                ph <= PH_RD;
                            end else begin
                                ph        <= PH_CMD;
                                stream_on <= 1'b0;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                    default: ph <= PH_CMD;
                endcase
            end else if (sclk_fall && ph == PH_RD) begin
                if (!started && cnt == '0) begin
                    tx      <= rd_word << (CW'(MAXW) - len);
                    started <= 1'b1;
                end else if (started) begin
                    tx <= tx << 1;
                end
            end
        end
    end

    assign dout = (ph == PH_RD && started) ? tx[MAXW-1] : rdy_n;

    // R13: read shift moves only on a detected falling edge
    assert_tx_edge_R13: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(tx));

    // R11: a closed frame leaves the port at a command or stream boundary
    assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (ph == PH_CMD) || stream_on);

endmodule

// File: rtl/cvt_regs.sv
module cvt_regs
    import cvt_pkg::*;
#(
    parameter int DATA_W = 24,
    localparam int MAXW  = (DATA_W > CTRL_W) ? DATA_W : CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_sel_e          sel,
    input  logic              wr_stb,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rd_done,
    input  logic              stream_on,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              upd_near,
    output logic [MAXW-1:0]   rd_word,
    output logic              rdy_n,
    output logic [3:0]        rate_code,
    output notch_e            notch
);
    logic [CTRL_W-1:0] mode_q, setup_q;
    logic [DATA_W-1:0] result_q;
    logic              fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_RST;
            setup_q  <= SETUP_RST;
            result_q <= '0;
            fresh    <= 1'b0;
            rdy_n    <= 1'b1;
        end else begin
            if (wr_stb) begin
                case (sel)
                    SEL_MODE:  mode_q  <= wr_data;
                    SEL_SETUP: setup_q <= wr_data;
                    default:   ;
                endcase
            end
            if (conv_done) begin
                result_q <= conv_word;
                fresh    <= 1'b1;
                rdy_n    <= 1'b0;
            end else begin
                if (rd_done && sel == SEL_RESULT) begin
                    fresh <= 1'b0;
                    rdy_n <= 1'b1;
                end
                if (upd_near) rdy_n <= 1'b1;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_STATUS: rd_word = MAXW'({rdy_n, stream_on, 6'b0});
            SEL_MODE:   rd_word = MAXW'(mode_q);
            SEL_SETUP:  rd_word = MAXW'(setup_q);
            SEL_RESULT: rd_word = (stream_on && !fresh) ? MAXW'({DATA_W{1'b1}})
                                                        : MAXW'(result_q);
            default:    rd_word = '0;
        endcase
    end

    assign rate_code = mode_q[3:0];
    assign notch     = notch_of(mode_q[3:0]);

    // R5: a finished conversion pulls ready low
    assert_rdy_low_R5: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !rdy_n);

    // R6: finishing a result read releases ready
    assert_rdy_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_done && sel == SEL_RESULT && !conv_done) |=> rdy_n);

    // R7: imminent update releases ready
    assert_rdy_upd_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_near && !conv_done) |=> rdy_n);

    // R3: a mode write reaches the rate field
    assert_mode_wr_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && sel == SEL_MODE) |=> (rate_code == $past(wr_data[3:0])));

endmodule

// File: rtl/cvt_serial_port.sv
module cvt_serial_port
    import cvt_pkg::*;
#(
    parameter int DATA_W = 24,
    localparam int MAXW  = (DATA_W > CTRL_W) ? DATA_W : CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              upd_near,
    output logic [3:0]        rate_code,
    output logic [1:0]        notch
);
    logic              frame_on, frame_end, sclk_rise, sclk_fall, din_s;
    reg_sel_e          sel;
    logic              wr_stb, rd_done, stream_on, rdy_n;
    logic [CTRL_W-1:0] wr_data;
    logic [MAXW-1:0]   rd_word;
    notch_e            notch_q;

    cvt_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .frame_on  (frame_on),
        .frame_end (frame_end),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s)
    );

    cvt_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .frame_on  (frame_on),
        .frame_end (frame_end),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s),
        .rd_word   (rd_word),
        .rdy_n     (rdy_n),
        .sel       (sel),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_done   (rd_done),
        .stream_on (stream_on),
        .dout      (dout)
    );

    cvt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .rd_done   (rd_done),
        .stream_on (stream_on),
        .conv_done (conv_done),
        .conv_word (conv_word),
        .upd_near  (upd_near),
        .rd_word   (rd_word),
        .rdy_n     (rdy_n),
        .rate_code (rate_code),
        .notch     (notch_q)
    );

    assign dout_oe = frame_on;
    assign notch   = notch_q;

endmodule

// File: tb/test_cvt_serial_port.sv
module test_cvt_serial_port;
    localparam int DW = 24;
    localparam int H  = 6;

    logic          clk = 1'b0;
    logic          rst, cs_n, sclk, din, conv_done, upd_near;
    logic [DW-1:0] conv_word;
    logic          dout, dout_oe;
    logic [3:0]    rate_code;
    logic [1:0]    notch;

    int n_chk = 0;
    int n_err = 0;

    // behavioural model state
    logic          busy;
    logic [15:0]   m_mode;
    logic          m_rdy_n;
    logic          h0 = 1'b1, h1 = 1'b1;
    logic [31:0]   r;

    always #5 clk = ~clk;

    cvt_serial_port #(.DATA_W(DW)) i_cvt_serial_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .conv_done(conv_done),
        .conv_word(conv_word), .upd_near(upd_near),
        .rate_code(rate_code), .notch(notch)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_notch(input logic [3:0] fs);
        if (fs == 4'd8)  return 2'd1;
        if (fs == 4'd9)  return 2'd2;
        if (fs == 4'd10) return 2'd3;
        return 2'd0;
    endfunction

    // chip-select history, mirrors the two-stage input path
    always @(posedge clk) begin
        h0 <= cs_n;
        h1 <= h0;
    end

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R1 oe", dout_oe, !h1);
            if (!busy) begin
                chk("R3 rate", rate_code, m_mode[3:0]);
                chk("R4 notch", notch, exp_notch(m_mode[3:0]));
                if (dout_oe) chk("R5 ready pin", dout, m_rdy_n);
            end
        end
    end

    task automatic shift(input logic [31:0] ov, input int n, input logic rd_chk,
                         output logic [31:0] iv);
        logic a;
        iv = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; din = ov[i];
            repeat (H) @(negedge clk);
            a  = dout;
            iv = {iv[30:0], a};
            sclk = 1'b1;
            repeat (H - 1) @(negedge clk);
            if (rd_chk && i > 0) chk("R13 bit held while high", dout, a);
            @(negedge clk);
        end
    endtask

    task automatic op(input logic [7:0] cmd, input logic [31:0] ov, input int n,
                      output logic [31:0] iv);
        logic [31:0] junk;
        busy = 1'b1;
        shift(32'(cmd), 8, 1'b0, junk);
        iv = '0;
        if (n > 0) shift(ov, n, cmd[6], iv);
        repeat (4) @(negedge clk);
    endtask

    task automatic word(input logic [31:0] ov, output logic [31:0] iv);
        busy = 1'b1;
        shift(ov, DW, 1'b1, iv);
        repeat (4) @(negedge clk);
    endtask

    task automatic release_bus();
        @(negedge clk); busy = 1'b0;
    endtask

    task automatic set_cs(input logic v);
        busy = 1'b1;
        @(negedge clk); cs_n = v;
        repeat (4) @(negedge clk);
        release_bus();
    endtask

    task automatic conv(input logic [DW-1:0] w);
        busy = 1'b1;
        @(negedge clk); conv_done = 1'b1; conv_word = w;
        @(negedge clk); conv_done = 1'b0;
        m_rdy_n = 1'b0;
        @(negedge clk); busy = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b1; din = 1'b0;
        conv_done = 1'b0; conv_word = '0; upd_near = 1'b0; busy = 1'b1;
        m_mode = 16'h000A; m_rdy_n = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", dout_oe, 1'b0);
        chk("R3 reset rate", rate_code, 4'hA);
        chk("R4 reset notch", notch, 2'd3);
        busy = 1'b0;

        set_cs(1'b0);
        // R12: idle status
        op(8'h40, 0, 8, r);  chk("R12 status idle", r, 32'h80); release_bus();
        op(8'h50, 0, 16, r); chk("R3 setup reset", r, 32'h0710); release_bus();

        // R3/R4: mode writes and readback
        op(8'h08, 32'h0008, 16, r); m_mode = 16'h0008; release_bus();
        chk("R4 60Hz", notch, 2'd1);
        op(8'h48, 0, 16, r); chk("R3 mode readback", r, 32'h0008); release_bus();
        op(8'h08, 32'h0009, 16, r); m_mode = 16'h0009; release_bus();
        chk("R4 50Hz", notch, 2'd2);
        op(8'h08, 32'h0005, 16, r); m_mode = 16'h0005; release_bus();
        chk("R4 other code", notch, 2'd0);
        op(8'h08, 32'h000A, 16, r); m_mode = 16'h000A; release_bus();
        op(8'h10, 32'h1234, 16, r); release_bus();
        op(8'h50, 0, 16, r); chk("R3 setup readback", r, 32'h1234); release_bus();

        // R2: byte with bit 7 set is dropped
        op(8'h88, 0, 0, r); release_bus();
        op(8'h48, 0, 16, r); chk("R2 dropped byte", r, 32'h000A); release_bus();

        // R5/R12/R6/R8: result path
        conv(24'hC0FFEE);
        chk("R5 ready low", dout, 1'b0);
        op(8'h40, 0, 8, r);  chk("R12 status ready", r, 32'h00); release_bus();
        op(8'h58, 0, DW, r); m_rdy_n = 1'b1;
        chk("R6 result", r, 32'hC0FFEE);
        chk("R6 pin high after read", dout, 1'b1);
        release_bus();
        op(8'h58, 0, DW, r); chk("R8 reread", r, 32'hC0FFEE); release_bus();

        // R7: update close without a read
        conv(24'h123456);
        busy = 1'b1;
        @(negedge clk); upd_near = 1'b1;
        @(negedge clk); upd_near = 1'b0; m_rdy_n = 1'b1;
        @(negedge clk);
        chk("R7 pin high", dout, 1'b1);
        busy = 1'b0;
        op(8'h58, 0, DW, r); chk("R7 word kept", r, 32'h123456); release_bus();

        // R11: aborted command and aborted write data
        busy = 1'b1;
        shift(32'h0, 4, 1'b0, r);
        set_cs(1'b1); set_cs(1'b0);
        op(8'h48, 0, 16, r); chk("R11 after short cmd", r, 32'h000A); release_bus();
        op(8'h08, 32'hFF, 8, r); release_bus();
        set_cs(1'b1); set_cs(1'b0);
        op(8'h48, 0, 16, r); chk("R11 after short write", r, 32'h000A); release_bus();

        // R9: continuous read
        conv(24'h800001);
        op(8'h5C, 0, DW, r); m_rdy_n = 1'b1;
        chk("R9 first stream word", r, 32'h800001); release_bus();
        word(0, r); chk("R9 stale word", r, 32'hFFFFFF); release_bus();
        conv(24'h7FFFFE);
        chk("R5 ready low in stream", dout, 1'b0);
        word(0, r); m_rdy_n = 1'b1;
        chk("R9 next stream word", r, 32'h7FFFFE); release_bus();
        set_cs(1'b1); set_cs(1'b0);
        conv(24'h00ABCD);
        word(0, r); m_rdy_n = 1'b1;
        chk("R9 stream across frames", r, 32'h00ABCD); release_bus();

        // R10: leave continuous read
        conv(24'h111111);
        word(32'h580000, r); m_rdy_n = 1'b1;
        chk("R10 last stream word", r, 32'h111111); release_bus();
        op(8'h40, 0, 8, r); chk("R10 status after exit", r, 32'h80); release_bus();

        set_cs(1'b1);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule